// File: doc/BRIEF.md
# Masked Internal Control Register File

This block holds a bank of 64-bit internal control registers addressed by a 6-bit index. There is one write port and one read port. Each register has its own write rule. Most keep only the bits of a fixed write mask. Some clear to zero on any write. Some cannot be written, some cannot be read, and the rest of the index space does not exist at all. Any access the register does not accept raises a fault flag and changes nothing.

Two registers behave differently from the rest. A read of the cycle-counter register returns its stored upper half joined to the lower 32 bits of a live cycle count. The counter-control register latches a one after its first write, whatever data that write carries. Writes to the two translation invalidate-all registers store zero and send a one-cycle flush strobe to the translation buffers, which sit outside this block.

Read data, the fault flag and the strobes are registered. They are valid in the cycle after the request. A read issued in the same cycle as a write to the same index returns the value held before that write.

Top module: `ctlreg_file`

## Requirements
- R1: After reset every index reads zero, with two exceptions: the machine-control register (index 17) reads 0x6 and the base register (index 16) reads the BASE_RST parameter.
- R2: A write stores `wr_data & mask`. The masks are: indices 19 and 20 keep 0xf; 21 keeps 0x1f; 22 and 23 keep 0x18; 25 keeps 0xffffff0300; 26 and 27 keep 0xffffffffc0000000; 28 keeps 0x1ffb; 29 and 30 keep 0x3f; 31 keeps 0x7f0; 32 keeps 0xfe00000000000000; 48 keeps 0x7fff0.
- R3: A write to the exception return address (index 18) stores the data with bit 1 forced to zero and every other bit kept.
- R4: Any write to index 33 or 34 clears that register to zero, whatever the data.
- R5: A write to a read-only index (35 to 39) raises `fault` and leaves the register unchanged. A read of these indices returns the stored value, which stays zero.
- R6: A read of a write-only index (24, 42 to 47) raises `fault` and returns zero on `rd_data`.
- R7: A read of the cycle-counter register (index 40) returns the stored bits 63:32 and, in bits 31:0, the `cycle_cnt` value sampled in the request cycle. A write to index 40 stores all 64 bits.
- R8: Any write to the counter-control register (index 41) sets it to 1, whatever the data.
- R9: A write to index 46 or 47 stores zero and pulses `flush_dtb` or `flush_itb` respectively for exactly the next cycle. A read of either index faults.
- R10: Indices 49 to 63 fault on both read and write. A read of one returns zero.
- R11: `rd_data` and `fault` reflect the request of the previous cycle. `fault` is the OR of the read and write faults. A cycle with no request gives `fault` low and `rd_data` zero. A same-cycle read and write of one index returns the old value.
- R12: Indices 0 to 17 store all 64 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Read index |
| cycle_cnt | input | 32 | Lower bits of the free-running cycle count |
| rd_data | output | 64 | Read result, one cycle after the request |
| fault | output | 1 | Access fault for the previous cycle's requests |
| flush_dtb | output | 1 | Data-side translation invalidate-all strobe |
| flush_itb | output | 1 | Instruction-side translation invalidate-all strobe |

## Verification
Several rules are checked by assertions on every cycle: faults on unknown, read-only and write-only indices, the zero returned by a faulting read, the quiet outputs after an idle cycle, the live lower half of a counter read, and the rule that each flush strobe follows a write to its own index. Other behaviour can only be shown by the bench's scenarios, because it depends on what was stored earlier. These are the per-register masks, the clear-on-write and latch-to-one rules, the reset values, the unchanged contents after a rejected write, and the old value returned by a same-cycle read and write. The bench shows them by writing patterns to every index and reading each one back against a behavioural model.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  typedef enum logic [2:0] {
    K_RW,     // masked read/write
    K_CLR,    // any write clears
    K_RO,     // write faults
    K_WO,     // read faults, write stores
    K_INV,    // read faults, write stores zero and strobes
    K_CC,     // cycle counter, merged read
    K_LATCH,  // write sets to one
    K_NONE    // no register: faults both ways
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [63:0] mask;
  } attr_t;

  localparam int unsigned IDX_BASE    = 16;
  localparam int unsigned IDX_MCTL    = 17;
  localparam int unsigned IDX_CC      = 40;
  localparam int unsigned IDX_DTB_INV = 46;
  localparam int unsigned IDX_ITB_INV = 47;
  localparam int unsigned IDX_LAST    = 48;

  function automatic attr_t reg_attr(input int unsigned idx);
    attr_t a;
    a.kind = K_RW;
    a.mask = '1;
    if (idx <= 17) begin
      a.kind = K_RW;
    end else begin
      case (idx)
        18:               a.mask = ~64'h2;
        19, 20:           a.mask = 64'hf;
        21:               a.mask = 64'h1f;
        22, 23:           a.mask = 64'h18;
        24:               begin a.kind = K_WO; a.mask = 64'h18; end
        25:               a.mask = 64'hff_ffff_0300;
        26, 27:           a.mask = 64'hffff_ffff_c000_0000;
        28:               a.mask = 64'h1ffb;
        29, 30:           a.mask = 64'h3f;
        31:               a.mask = 64'h7f0;
        32:               a.mask = 64'hfe00_0000_0000_0000;
        33, 34:           a.kind = K_CLR;
        35, 36, 37, 38, 39: a.kind = K_RO;
        40:               a.kind = K_CC;
        41:               a.kind = K_LATCH;
        42, 43, 44, 45:   a.kind = K_WO;
        46, 47:           a.kind = K_INV;
        48:               a.mask = 64'h7fff0;
        default:          a.kind = K_NONE;
      endcase
    end
    return a;
  endfunction

  function automatic logic [63:0] reg_rst(input int unsigned idx, input logic [63:0] base);
    if (idx == IDX_BASE) return base;
    if (idx == IDX_MCTL) return 64'h6;
    return '0;
  endfunction

endpackage

// File: rtl/ctlreg_rst_sync.sv
module ctlreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ctlreg_wr_path.sv
module ctlreg_wr_path
  import ctlreg_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  output logic             wr_fault,
  output logic             wr_commit,
  output logic [63:0]      wr_val,
  output logic             inv_dtb,
  output logic             inv_itb
);
  attr_t attr;

  always_comb begin
    attr      = reg_attr(32'(wr_idx));
    wr_fault  = wr_en && (attr.kind == K_RO || attr.kind == K_NONE);
    wr_commit = wr_en && !(attr.kind == K_RO || attr.kind == K_NONE);
    unique case (attr.kind)
      K_CLR, K_INV: wr_val = '0;
      K_LATCH:      wr_val = 64'h1;
      default:      wr_val = wr_data & attr.mask;
    endcase
    inv_dtb = wr_en && (32'(wr_idx) == IDX_DTB_INV);
    inv_itb = wr_en && (32'(wr_idx) == IDX_ITB_INV);
  end
endmodule

// File: rtl/ctlreg_rd_path.sv
module ctlreg_rd_path
  import ctlreg_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [63:0]      rd_val,
  input  logic [31:0]      cycle_cnt,
  output logic             rd_fault,
  output logic [63:0]      rd_next
);
  kind_e kind;

  always_comb begin
    kind     = reg_attr(32'(rd_idx)).kind;
    rd_fault = rd_en && (kind == K_WO || kind == K_INV || kind == K_NONE);
    rd_next  = '0;
    if (rd_en && !rd_fault) begin
      if (kind == K_CC) rd_next = {rd_val[63:32], cycle_cnt};
      else              rd_next = rd_val;
    end
  end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int          IDX_W    = 6,
  parameter logic [63:0] BASE_RST = 64'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_commit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_val
);
  localparam int NUM_REG = 1 << IDX_W;

  logic [63:0] ent [NUM_REG];

  for (genvar i = 0; i < NUM_REG; i++) begin : g_ent
    localparam attr_t A = reg_attr(i);
    if (A.kind != K_NONE && A.kind != K_RO) begin : g_ff
      logic        en;
      logic [63:0] q;
      assign en = wr_commit && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= reg_rst(i, BASE_RST);
        else if (en) q <= wr_val;
      end
      assign ent[i] = q;
    end else begin : g_none
      assign ent[i] = '0;
    end
  end

  assign rd_val = ent[rd_idx];
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
  import ctlreg_pkg::*;
#(
  parameter int          IDX_W    = 6,
  parameter logic [63:0] BASE_RST = 64'h0000_0000_0001_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [31:0]      cycle_cnt,
  output logic [63:0]      rd_data,
  output logic             fault,
  output logic             flush_dtb,
  output logic             flush_itb
);
  logic        rst_sync_n;
  logic        wr_fault, wr_commit, inv_dtb, inv_itb;
  logic [63:0] wr_val, rd_val, rd_next;
  logic        rd_fault;
  logic        fault_d;

  ctlreg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  ctlreg_wr_path #(.IDX_W(IDX_W)) u_wr (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_fault(wr_fault), .wr_commit(wr_commit), .wr_val(wr_val),
    .inv_dtb(inv_dtb), .inv_itb(inv_itb)
  );

  ctlreg_bank #(.IDX_W(IDX_W), .BASE_RST(BASE_RST)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_commit(wr_commit), .wr_idx(wr_idx),
    .wr_val(wr_val), .rd_idx(rd_idx), .rd_val(rd_val)
  );

  ctlreg_rd_path #(.IDX_W(IDX_W)) u_rd (
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_val(rd_val), .cycle_cnt(cycle_cnt),
    .rd_fault(rd_fault), .rd_next(rd_next)
  );

  always_comb fault_d = rd_fault || wr_fault;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data   <= '0;
      fault     <= 1'b0;
      flush_dtb <= 1'b0;
      flush_itb <= 1'b0;
    end else begin
      rd_data   <= rd_next;
      fault     <= fault_d;
      flush_dtb <= inv_dtb;
      flush_itb <= inv_itb;
    end
  end
endmodule

// File: rtl/ctlreg_file_chk.sv
module ctlreg_file_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_idx,
  input logic [31:0]      cycle_cnt,
  input logic [63:0]      rd_data,
  input logic             fault,
  input logic             flush_dtb,
  input logic             flush_itb
);
  logic rd_none, wr_none, rd_wo, wr_ro;
  assign rd_none = rd_en && (32'(rd_idx) > 48);
  assign wr_none = wr_en && (32'(wr_idx) > 48);
  assign rd_wo   = rd_en && (32'(rd_idx) == 24 || (32'(rd_idx) >= 42 && 32'(rd_idx) <= 47));
  assign wr_ro   = wr_en && (32'(wr_idx) >= 35 && 32'(wr_idx) <= 39);

  AST_UNKNOWN_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_none || wr_none) |=> fault); // R10
  AST_UNKNOWN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_none |=> rd_data == 64'h0); // R10
  AST_WO_READ_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wo |=> (fault && rd_data == 64'h0)); // R6
  AST_RO_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ro |=> fault); // R5
  AST_CC_LOW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && 32'(rd_idx) == 40) |=> rd_data[31:0] == $past(cycle_cnt)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |=> (!fault && rd_data == 64'h0 && !flush_dtb && !flush_itb)); // R11
  AST_DTB_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(wr_idx) == 46) |=> (flush_dtb && !flush_itb)); // R9
  AST_ITB_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(wr_idx) == 47) |=> (flush_itb && !flush_dtb)); // R9
endmodule

bind ctlreg_file ctlreg_file_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .rd_en(rd_en), .rd_idx(rd_idx), .cycle_cnt(cycle_cnt), .rd_data(rd_data),
  .fault(fault), .flush_dtb(flush_dtb), .flush_itb(flush_itb)
);

// File: tb/ctlreg_file_tb.sv
module ctlreg_file_tb;
  localparam logic [63:0] BASE = 64'h0000_0000_0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  wr_idx = '0, rd_idx = '0;
  logic [63:0] wr_data = '0;
  logic [31:0] cycle_cnt = '0;
  logic [63:0] rd_data;
  logic        fault, flush_dtb, flush_itb;

  int errors = 0;
  int checks = 0;
  logic [63:0] m [64];
  logic [63:0] cc = 64'h0;

  always #4 clk = ~clk;

  ctlreg_file #(.IDX_W(6), .BASE_RST(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .cycle_cnt(cycle_cnt), .rd_data(rd_data),
    .fault(fault), .flush_dtb(flush_dtb), .flush_itb(flush_itb)
  );

  function automatic logic [63:0] keep_bits(int i);
    case (i)
      18: return ~64'h2;
      19, 20: return 64'hf;
      21: return 64'h1f;
      22, 23, 24: return 64'h18;
      25: return 64'hff_ffff_0300;
      26, 27: return 64'hffff_ffff_c000_0000;
      28: return 64'h1ffb;
      29, 30: return 64'h3f;
      31: return 64'h7f0;
      32: return 64'hfe00_0000_0000_0000;
      48: return 64'h7fff0;
      default: return '1;
    endcase
  endfunction

  function automatic bit can_read(int i);
    return !(i == 24 || (i >= 42 && i <= 47) || i > 48);
  endfunction

  function automatic bit can_write(int i);
    return !((i >= 35 && i <= 39) || i > 48);
  endfunction

  function automatic string tag(int i);
    if (i <= 17) return "R12";
    if (i == 18) return "R3";
    if (i == 33 || i == 34) return "R4";
    if (i >= 35 && i <= 39) return "R5";
    if (i == 24 || (i >= 42 && i <= 45)) return "R6";
    if (i == 40) return "R7";
    if (i == 41) return "R8";
    if (i == 46 || i == 47) return "R9";
    if (i > 48) return "R10";
    return "R2";
  endfunction

  task automatic step(string req, bit we, int wi, logic [63:0] wd, bit re, int ri);
    logic [63:0] e_rd = '0;
    bit e_f = 0, e_fd = 0, e_fi = 0;
    cc = cc + 64'h0000_0001_2345_6789;
    if (re) begin
      if (!can_read(ri)) e_f = 1;
      else if (ri == 40) e_rd = {m[40][63:32], cc[31:0]};
      else e_rd = m[ri];
    end
    if (we) begin
      if (!can_write(wi)) e_f = 1;
      else if (wi == 33 || wi == 34 || wi == 46 || wi == 47) m[wi] = '0;
      else if (wi == 41) m[wi] = 64'h1;
      else m[wi] = wd & keep_bits(wi);
      e_fd = (wi == 46);
      e_fi = (wi == 47);
    end
    wr_en = we; wr_idx = 6'(wi); wr_data = wd;
    rd_en = re; rd_idx = 6'(ri); cycle_cnt = cc[31:0];
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    checks++;
    if (rd_data !== e_rd || fault !== e_f || flush_dtb !== e_fd || flush_itb !== e_fi) begin
      errors++;
      $display("FAIL %s wr=%0b/%0d rd=%0b/%0d: rd_data=%h fault=%b fd=%b fi=%b expected rd_data=%h fault=%b fd=%b fi=%b",
               req, we, wi, re, ri, rd_data, fault, flush_dtb, flush_itb, e_rd, e_f, e_fd, e_fi);
    end
  endtask

  task automatic write_all_read_back(logic [63:0] pat);
    for (int i = 0; i < 64; i++) step(tag(i), 1, i, pat ^ 64'(i), 0, 0);
    for (int i = 0; i < 64; i++) step(tag(i), 0, 0, '0, 1, i);
  endtask

  initial begin
    #1_600_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m[i] = '0;
    m[16] = BASE;
    m[17] = 64'h6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rd_data !== 64'h0 || fault !== 1'b0 || flush_dtb !== 1'b0 || flush_itb !== 1'b0) begin
      errors++;
      $display("FAIL R1 outputs in reset: rd_data=%h fault=%b expected 0 0", rd_data, fault);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 64; i++) step("R1", 0, 0, '0, 1, i);

    write_all_read_back(64'hffff_ffff_ffff_ffff);
    write_all_read_back(64'ha5a5_5a5a_c3c3_3c3c);
    write_all_read_back(64'h0123_4567_89ab_cdef);

    // R3: bit 1 of exception address is cleared, others kept
    step("R3", 1, 18, 64'h0000_0000_0000_0003, 0, 0);
    step("R3", 0, 0, '0, 1, 18);

    // R4: clear-on-write with nonzero data
    step("R4", 1, 33, 64'hdead_beef, 0, 0);
    step("R4", 0, 0, '0, 1, 33);

    // R5: rejected write leaves contents unchanged
    step("R5", 1, 37, 64'hffff, 0, 0);
    step("R5", 0, 0, '0, 1, 37);

    // R7: counter stored upper half with live lower half
    step("R7", 1, 40, 64'h7777_8888_9999_aaaa, 0, 0);
    for (int k = 0; k < 4; k++) step("R7", 0, 0, '0, 1, 40);

    // R8: latch sets to one even for zero data, repeated
    step("R8", 1, 41, 64'h0, 0, 0);
    step("R8", 1, 41, 64'h0, 1, 41);
    step("R8", 0, 0, '0, 1, 41);

    // R9: back-to-back invalidates, then idle
    step("R9", 1, 46, 64'h55, 0, 0);
    step("R9", 1, 47, 64'h55, 0, 0);
    step("R9", 0, 0, '0, 0, 0);

    // R10: unknown index both ways in the same cycle
    step("R10", 1, 60, 64'h1, 1, 63);

    // R11: same-cycle read and write returns old value; fault is OR
    step("R11", 1, 5, 64'h1111_2222_3333_4444, 0, 0);
    step("R11", 1, 5, 64'h5555_6666_7777_8888, 1, 5);
    step("R11", 0, 0, '0, 1, 5);
    step("R11", 1, 36, 64'h1, 1, 5);
    step("R11", 1, 5, 64'h1, 1, 44);
    step("R11", 0, 0, '0, 0, 0);

    // R2: masked registers with a pattern only in masked-off bits
    step("R2", 1, 21, 64'hffff_ffff_ffff_ffe0, 0, 0);
    step("R2", 0, 0, '0, 1, 21);
    step("R2", 1, 48, 64'h0000_0000_0008_000f, 0, 0);
    step("R2", 0, 0, '0, 1, 48);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule